// File: doc/BRIEF.md
# Four-Level Performance Point Controller

This block is the register-controlled core of a CPU performance scaler. Software stores up to four operating points, each made of a clock divider, a clock-source select, a PLL-source select and a supply-voltage select. A small load register then picks which point the CPU runs at. From the chosen point the block produces a periodic clock-enable pulse, which gates the CPU clock down to the divided rate, and the select outputs that steer the clock muxes and the voltage regulator.

Software is expected to program the four points with scaling switched off. It then sets the load level to 0, the fastest point, and finally raises the master enable. Separate per-field enables decide whether the divider, the voltage select, the clock-source select and the PLL select follow the active point or stay at the point-0 value. Any change of point or divider is held back until the current divided period ends, so the CPU never sees a shortened clock period.

A two-state machine holds the applied mode: FULL (scaling off, pulse on every cycle, all selects zero) and SCALED (pulse every N cycles, selects from the chosen point). The FULL to SCALED transition (enable_seen) and the SCALED to FULL transition (enable_dropped) are both taken only on a period boundary. Otherwise each state holds at a boundary (stay_full, stay_scaled).

Top module: `dvfs_level_ctrl`

## Requirements
- R1: After reset every register reads zero, cpu_clk_en is high on every cycle, and vdd_sel, clk_src_sel and pll_src_sel are 0.
- R2: The point registers sit at 0x18 (points 0 and 1) and 0x1C (points 2 and 3). The even point uses bits 31:16 and the odd point uses bits 15:0. Within a half-word the divider is at bits 15:13, clock source at bit 11, PLL source at bits 10:9 and voltage select at bits 7:6. All other bits read 0, so writing all ones reads back 0xEEC0EEC0.
- R3: The enable register at 0x24 keeps only master (bit 31), voltage (30), divider (29), PLL (28) and clock-source (26). Writing all ones reads back 0xF4000000. The load register at 0x30 keeps bits 1:0 only.
- R4: Addresses other than 0x18, 0x1C, 0x24 and 0x30 read as zero, and writes to them change nothing.
- R5: While master is clear, cpu_clk_en is high every cycle and all three select outputs are 0, whatever the other enables and points hold.
- R6: With master and divider enable set, cpu_clk_en pulses once every D cycles, where D is the active point's divider. A divider of 0 acts as 1.
- R7: With master and the matching field enables set, vdd_sel, clk_src_sel and pll_src_sel equal the active point's fields.
- R8: With master set, each clear field enable makes that output, or the pulse period, take point 0's value.
- R9: A change of point, divider or select takes effect only on the cycle after a pulse. The period in flight keeps its old length, and the outputs do not change between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe, whole word |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| cpu_clk_en | output | 1 | Divided clock-enable pulse |
| vdd_sel | output | 2 | Supply-voltage select |
| clk_src_sel | output | 1 | CPU clock-source select |
| pll_src_sel | output | 2 | PLL-source select |

## Verification
The key overlap is a register write that changes the load level while a divided period is still running. The write and the period-end boundary fall in neighbouring cycles, and the write must not cut the running period short. The bench lets a divide-by-6 period start, writes a new point two cycles into it, and then checks three things: the voltage select has not yet changed, the next gap is still 6, and both the new voltage and the new gap of 1 appear only after that pulse. A full sweep of all four points and all eight divider codes then checks the pulse period and the selects arithmetically.

// File: rtl/dvfs_pkg.sv
package dvfs_pkg;
    parameter int DIV_W   = 3;
    parameter int PLL_W   = 2;
    parameter int VDD_W   = 2;
    parameter int LVL_N   = 4;
    localparam int LVL_W  = $clog2(LVL_N);
    localparam int HALF_W = 16;

    // field positions inside one point's half-word
    localparam int DIV_LSB  = 13;
    localparam int CSEL_BIT = 11;
    localparam int PLL_LSB  = 9;
    localparam int VDD_LSB  = 6;

    // enable register bits
    localparam int EN_CSEL   = 26;
    localparam int EN_PLL    = 28;
    localparam int EN_DIV    = 29;
    localparam int EN_VDD    = 30;
    localparam int EN_MASTER = 31;

    localparam int CFG_BASE = 'h18;
    localparam int DYN_ADDR = 'h24;
    localparam int LVL_ADDR = 'h30;

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic             csel;
        logic [PLL_W-1:0] pll;
        logic [VDD_W-1:0] vdd;
    } lvl_cfg_t;

    typedef struct packed {
        logic master;
        logic vdd;
        logic div;
        logic pll;
        logic csel;
    } dyn_en_t;

    typedef enum logic [0:0] {
        ST_FULL   = 1'b0,
        ST_SCALED = 1'b1
    } gen_state_t;

    function automatic lvl_cfg_t unpack_half(input logic [HALF_W-1:0] h);
        lvl_cfg_t c;
        c.div  = h[DIV_LSB +: DIV_W];
        c.csel = h[CSEL_BIT];
        c.pll  = h[PLL_LSB +: PLL_W];
        c.vdd  = h[VDD_LSB +: VDD_W];
        return c;
    endfunction

    function automatic logic [HALF_W-1:0] pack_half(input lvl_cfg_t c);
        logic [HALF_W-1:0] h;
        h = '0;
        h[DIV_LSB +: DIV_W] = c.div;
        h[CSEL_BIT]         = c.csel;
        h[PLL_LSB +: PLL_W] = c.pll;
        h[VDD_LSB +: VDD_W] = c.vdd;
        return h;
    endfunction
endpackage

// File: rtl/dvfs_regfile.sv
module dvfs_regfile
    import dvfs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [31:0]               bus_wdata,
    input  logic                      bus_we,
    output logic [31:0]               bus_rdata,
    output lvl_cfg_t [LVL_N-1:0]      lvl_cfg,
    output dyn_en_t                   dyn_en,
    output logic [LVL_W-1:0]          load_lvl
);
    localparam logic [ADDR_W-1:0] A_DYN = ADDR_W'(DYN_ADDR);
    localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(LVL_ADDR);

    dyn_en_t          dyn_q;
    logic [LVL_W-1:0] lvl_q;

    // two points share each word: even point in upper half
    for (genvar i = 0; i < LVL_N; i++) begin : g_point
        localparam int SH = (i % 2 == 0) ? HALF_W : 0;
        localparam logic [ADDR_W-1:0] A_CFG = ADDR_W'(CFG_BASE + 4 * (i / 2));
        lvl_cfg_t pt_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pt_q <= '0;
            else if (bus_we && bus_addr == A_CFG)
                pt_q <= unpack_half(bus_wdata[SH +: HALF_W]);
        end
        assign lvl_cfg[i] = pt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dyn_q <= '0;
            lvl_q <= '0;
        end else if (bus_we) begin
            if (bus_addr == A_DYN) begin
                dyn_q.master <= bus_wdata[EN_MASTER];
                dyn_q.vdd    <= bus_wdata[EN_VDD];
                dyn_q.div    <= bus_wdata[EN_DIV];
                dyn_q.pll    <= bus_wdata[EN_PLL];
                dyn_q.csel   <= bus_wdata[EN_CSEL];
            end
            if (bus_addr == A_LVL)
                lvl_q <= bus_wdata[LVL_W-1:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < LVL_N / 2; k++) begin
            if (bus_addr == ADDR_W'(CFG_BASE + 4 * k))
                bus_rdata = {pack_half(lvl_cfg[2*k]), pack_half(lvl_cfg[2*k+1])};
        end
        if (bus_addr == A_DYN) begin
            bus_rdata[EN_MASTER] = dyn_q.master;
            bus_rdata[EN_VDD]    = dyn_q.vdd;
            bus_rdata[EN_DIV]    = dyn_q.div;
            bus_rdata[EN_PLL]    = dyn_q.pll;
            bus_rdata[EN_CSEL]   = dyn_q.csel;
        end
        if (bus_addr == A_LVL)
            bus_rdata[LVL_W-1:0] = lvl_q;
    end

    assign dyn_en   = dyn_q;
    assign load_lvl = lvl_q;
endmodule

// File: rtl/dvfs_level_mux.sv
module dvfs_level_mux
    import dvfs_pkg::*;
(
    input  lvl_cfg_t [LVL_N-1:0] lvl_cfg,
    input  dyn_en_t              dyn_en,
    input  logic [LVL_W-1:0]     load_lvl,
    output lvl_cfg_t             tgt,
    output logic                 tgt_scaled
);
    lvl_cfg_t act;
    lvl_cfg_t base;

    always_comb begin
        act  = lvl_cfg[load_lvl];
        base = lvl_cfg[0];
        tgt  = '0;
        tgt.div = DIV_W'(1);
        if (dyn_en.master) begin
            tgt.div  = dyn_en.div  ? act.div  : base.div;
            tgt.vdd  = dyn_en.vdd  ? act.vdd  : base.vdd;
            tgt.pll  = dyn_en.pll  ? act.pll  : base.pll;
            tgt.csel = dyn_en.csel ? act.csel : base.csel;
        end
        if (tgt.div == '0)
            tgt.div = DIV_W'(1);
    end

    assign tgt_scaled = dyn_en.master;
endmodule

// File: rtl/dvfs_clk_gen.sv
module dvfs_clk_gen
    import dvfs_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  lvl_cfg_t         tgt,
    input  logic             tgt_scaled,
    output logic             cpu_clk_en,
    output logic [VDD_W-1:0] vdd_sel,
    output logic             clk_src_sel,
    output logic [PLL_W-1:0] pll_src_sel,
    output gen_state_t       state
);
    gen_state_t       state_q, state_d;
    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] div_q;
    lvl_cfg_t         app_q;
    logic             boundary;

    assign boundary = (cnt_q == div_q - DIV_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FULL:   state_d = tgt_scaled ? ST_SCALED : ST_FULL;   // enable_seen / stay_full
            ST_SCALED: state_d = tgt_scaled ? ST_SCALED : ST_FULL;   // stay_scaled / enable_dropped
            default:   state_d = ST_FULL;
        endcase
    end

    // state register and the period it governs, updated only at a boundary
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_FULL;
            cnt_q   <= '0;
            div_q   <= DIV_W'(1);
            app_q   <= '0;
        end else if (boundary) begin
            state_q <= state_d;
            cnt_q   <= '0;
            div_q   <= tgt.div;
            app_q   <= tgt;
        end else begin
            cnt_q   <= cnt_q + DIV_W'(1);
        end
    end

    always_comb begin
        cpu_clk_en  = boundary;
        vdd_sel     = '0;
        clk_src_sel = 1'b0;
        pll_src_sel = '0;
        unique case (state_q)
            ST_FULL: ;
            ST_SCALED: begin
                vdd_sel     = app_q.vdd;
                clk_src_sel = app_q.csel;
                pll_src_sel = app_q.pll;
            end
            default: ;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/dvfs_level_ctrl.sv
module dvfs_level_ctrl
    import dvfs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    input  logic              bus_we,
    output logic [31:0]       bus_rdata,
    output logic              cpu_clk_en,
    output logic [VDD_W-1:0]  vdd_sel,
    output logic              clk_src_sel,
    output logic [PLL_W-1:0]  pll_src_sel
);
    lvl_cfg_t [LVL_N-1:0] lvl_cfg;
    dyn_en_t              dyn_en;
    logic [LVL_W-1:0]     load_lvl;
    lvl_cfg_t             tgt;
    logic                 tgt_scaled;
    gen_state_t           gen_state;

    dvfs_regfile #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .lvl_cfg   (lvl_cfg),
        .dyn_en    (dyn_en),
        .load_lvl  (load_lvl)
    );

    dvfs_level_mux u_mux (
        .lvl_cfg    (lvl_cfg),
        .dyn_en     (dyn_en),
        .load_lvl   (load_lvl),
        .tgt        (tgt),
        .tgt_scaled (tgt_scaled)
    );

    dvfs_clk_gen u_gen (
        .clk         (clk),
        .rst_n       (rst_n),
        .tgt         (tgt),
        .tgt_scaled  (tgt_scaled),
        .cpu_clk_en  (cpu_clk_en),
        .vdd_sel     (vdd_sel),
        .clk_src_sel (clk_src_sel),
        .pll_src_sel (pll_src_sel),
        .state       (gen_state)
    );
endmodule

// File: rtl/dvfs_level_ctrl_chk.sv
module dvfs_level_ctrl_chk
    import dvfs_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              bus_we,
    input logic [31:0]       bus_rdata,
    input logic              cpu_clk_en,
    input logic [VDD_W-1:0]  vdd_sel,
    input logic              clk_src_sel,
    input logic [PLL_W-1:0]  pll_src_sel,
    input logic [LVL_W-1:0]  load_lvl,
    input gen_state_t        gen_state
);
    localparam int MAX_GAP = (1 << DIV_W) - 2;
    logic [DIV_W:0] gap_q;
    logic           mapped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          gap_q <= '0;
        else if (cpu_clk_en) gap_q <= '0;
        else                 gap_q <= gap_q + 1'b1;
    end

    always_comb begin
        mapped = (bus_addr == ADDR_W'(DYN_ADDR)) || (bus_addr == ADDR_W'(LVL_ADDR));
        for (int k = 0; k < LVL_N / 2; k++)
            if (bus_addr == ADDR_W'(CFG_BASE + 4 * k)) mapped = 1'b1;
    end

    // R5: FULL mode pulses every cycle with all selects at zero
    a_r5_full_mode: assert property (@(posedge clk) disable iff (!rst_n)
        gen_state == ST_FULL |-> cpu_clk_en && vdd_sel == '0 && pll_src_sel == '0 && !clk_src_sel);

    // R9: selects hold between pulses
    a_r9_hold_between_pulses: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(cpu_clk_en) |-> $stable(vdd_sel) && $stable(pll_src_sel) && $stable(clk_src_sel));

    // R6: no period longer than the largest divider
    a_r6_gap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        gap_q <= (DIV_W+1)'(MAX_GAP));

    // R3: a load write is kept in the load register
    a_r3_load_write: assert property (@(posedge clk) disable iff (!rst_n)
        $past(bus_we && bus_addr == ADDR_W'(LVL_ADDR)) |-> load_lvl == $past(bus_wdata[LVL_W-1:0]));

    // R4: holes in the map read zero
    a_r4_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !mapped |-> bus_rdata == '0);
endmodule

bind dvfs_level_ctrl dvfs_level_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_we      (bus_we),
    .bus_rdata   (bus_rdata),
    .cpu_clk_en  (cpu_clk_en),
    .vdd_sel     (vdd_sel),
    .clk_src_sel (clk_src_sel),
    .pll_src_sel (pll_src_sel),
    .load_lvl    (load_lvl),
    .gen_state   (gen_state)
);

// File: tb/sim_dvfs_level_ctrl.sv
`timescale 1ns/1ps
module sim_dvfs_level_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_rdata;
    logic        cpu_clk_en;
    logic [1:0]  vdd_sel;
    logic        clk_src_sel;
    logic [1:0]  pll_src_sel;

    int checks = 0;
    int errors = 0;
    int since = 0;
    int last_gap = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dvfs_level_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_rdata(bus_rdata), .cpu_clk_en(cpu_clk_en),
        .vdd_sel(vdd_sel), .clk_src_sel(clk_src_sel), .pll_src_sel(pll_src_sel)
    );

    // gap monitor: cycles from one pulse to the next
    always @(negedge clk) begin
        if (rst_n) begin
            if (cpu_clk_en) begin
                last_gap = since + 1;
                since = 0;
            end else begin
                since = since + 1;
            end
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(posedge clk); #1;
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a; #1;
        d = bus_rdata;
    endtask

    task automatic next_gap(output int g);
        do begin @(negedge clk); #1; end while (!cpu_clk_en);
        g = last_gap;
    endtask

    function automatic logic [15:0] half(input int dv, input int cs, input int pl, input int vd);
        return {dv[2:0], 1'b0, cs[0], pl[1:0], 1'b0, vd[1:0], 6'b0};
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        int g;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h18, r); chk("R1 cfg01", r, 0);
        rd(8'h1C, r); chk("R1 cfg23", r, 0);
        rd(8'h24, r); chk("R1 dyn", r, 0);
        rd(8'h30, r); chk("R1 load", r, 0);
        next_gap(g); next_gap(g);
        chk("R1 gap", g, 1);
        chk("R1 vdd", {30'b0, vdd_sel}, 0);

        // R2 / R3 / R4 layout and masking
        wr(8'h18, 32'hFFFF_FFFF); rd(8'h18, r); chk("R2 all ones", r, 32'hEEC0_EEC0);
        wr(8'h1C, 32'h1234_5678); rd(8'h1C, r); chk("R2 pattern", r, 32'h0200_4640);
        wr(8'h24, 32'hFFFF_FFFF); rd(8'h24, r); chk("R3 dyn mask", r, 32'hF400_0000);
        wr(8'h30, 32'hFFFF_FFFF); rd(8'h30, r); chk("R3 load mask", r, 3);
        wr(8'h20, 32'hFFFF_FFFF); wr(8'h2C, 32'hFFFF_FFFF);
        rd(8'h20, r); chk("R4 hole 0x20", r, 0);
        rd(8'h34, r); chk("R4 hole 0x34", r, 0);
        rd(8'h1C, r); chk("R4 no side effect", r, 32'h0200_4640);

        // R5 master clear, other enables set
        wr(8'h24, 32'h7400_0000);
        wr(8'h18, {half(4,1,3,2), half(5,1,2,1)});
        next_gap(g); next_gap(g); next_gap(g);
        chk("R5 gap", g, 1);
        chk("R5 sel", {27'b0, vdd_sel, clk_src_sel, pll_src_sel}, 0);

        // R6 / R7 sweep over points and divider codes
        wr(8'h24, 32'hF400_0000);
        for (int lv = 0; lv < 4; lv++) begin
            for (int d = 0; d < 8; d++) begin
                logic [15:0] h [4];
                for (int k = 0; k < 4; k++) h[k] = half(2, 0, 0, 0);
                h[lv] = half(d, lv % 2, lv, 3 - lv);
                wr(8'h18, {h[0], h[1]});
                wr(8'h1C, {h[2], h[3]});
                wr(8'h30, lv);
                next_gap(g); next_gap(g); next_gap(g);
                chk("R6 sweep gap", g, (d == 0) ? 1 : d);
                chk("R7 sweep vdd", {30'b0, vdd_sel}, 3 - lv);
                chk("R7 sweep pll", {30'b0, pll_src_sel}, lv);
                chk("R7 sweep csel", {31'b0, clk_src_sel}, lv % 2);
            end
        end

        // R8 field enables fall back to point 0
        wr(8'h18, {half(4,1,3,2), half(2,0,0,0)});
        wr(8'h1C, {half(2,0,0,0), half(6,0,1,1)});
        wr(8'h30, 3);
        wr(8'h24, 32'h8000_0000);
        next_gap(g); next_gap(g); next_gap(g);
        chk("R8 div from pt0", g, 4);
        chk("R8 vdd from pt0", {30'b0, vdd_sel}, 2);
        chk("R8 pll from pt0", {30'b0, pll_src_sel}, 3);
        chk("R8 csel from pt0", {31'b0, clk_src_sel}, 1);
        wr(8'h24, 32'hC000_0000);
        next_gap(g); next_gap(g); next_gap(g);
        chk("R8 vdd enabled only", {30'b0, vdd_sel}, 1);
        chk("R8 div still pt0", g, 4);
        wr(8'h24, 32'hA000_0000);
        next_gap(g); next_gap(g); next_gap(g);
        chk("R8 div enabled only", g, 6);
        chk("R8 vdd back to pt0", {30'b0, vdd_sel}, 2);

        // R9 load change in the middle of a period
        wr(8'h18, {half(6,0,0,0), half(1,1,2,3)});
        wr(8'h30, 0);
        wr(8'h24, 32'hF400_0000);
        next_gap(g); next_gap(g); next_gap(g);
        chk("R9 start gap", g, 6);
        repeat (2) @(negedge clk);
        #1 wr(8'h30, 1);
        @(negedge clk); #1;
        chk("R9 vdd held mid period", {30'b0, vdd_sel}, 0);
        next_gap(g);
        chk("R9 period in flight", g, 6);
        chk("R9 vdd at last old pulse", {30'b0, vdd_sel}, 0);
        next_gap(g);
        chk("R9 new gap", g, 1);
        chk("R9 new vdd", {30'b0, vdd_sel}, 3);
        chk("R9 new csel", {31'b0, clk_src_sel}, 1);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule